// File: doc/BRIEF.md
# One-Wire Bit Slot Engine

This block generates single bit time slots on an open-drain one-wire data line, acting as the bus master. A command selects one of three slot kinds: write a zero, write a one, or read a bit. The block pulls the line low for a time chosen by the command and then releases it so the external pull-up can raise it. It never drives the line high. After the release, a read slot watches the line and decides the bit from how soon the line comes back high.

All slot timings are parameters given in microseconds. They are counted against a microsecond tick built from the system clock by a prescaler of `CLK_PER_US` cycles. The prescaler restarts at every accepted command, so slot edges fall on exact clock counts from the start.

The surrounding logic pulses `start` with a command and waits for `done`. When `done` is high, `rd_bit` is valid. Byte assembly, reset and presence handling, and device search belong to a higher layer.

Top module: `ow_slot_engine`

## Requirements
- R1: A write-one command (`cmd` = 2'b01) holds `line_oe` high for exactly `T_LOW1*CLK_PER_US` cycles. The pull-down starts in the cycle after the clock edge that accepts `start`.
- R2: A write-zero command (`cmd` = 2'b00) holds `line_oe` high for exactly `T_LOW0*CLK_PER_US` cycles, starting in the same way.
- R3: A read command (`cmd` = 2'b10 or 2'b11, selected by `cmd[1]`) holds `line_oe` high for exactly `T_LOWR*CLK_PER_US` cycles and then releases the line.
- R4: Every slot, whatever its kind or its read result, keeps `busy` high for exactly `(T_SLOT+T_REC)*CLK_PER_US` cycles from the accepting edge. `done` is high for exactly the one cycle after `busy` falls.
- R5: A read slot returns `rd_bit` = 1 if the synchronized line is seen high while released and the whole microseconds elapsed since the slot start are still below `T_RDV`. Otherwise it returns 0.
- R6: `line_in` passes through a chain of `SYNC_STAGES` flip-flops (two by default) before the read decision uses it. A rising line is therefore counted only that many edges later.
- R7: A `start` pulse that arrives while `busy` is high is ignored. It changes neither the running slot's pull-down length nor its end, and it does not start a slot afterwards.
- R8: `rd_bit` changes only on the `done` cycle. It holds its value between slots, and a write slot sets it to 0.
- R9: While `rst` is high and after it is released, `busy`, `done`, `line_oe` and `rd_bit` are all 0 until a command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, accepted only while idle |
| cmd | input | 2 | 00 write zero, 01 write one, 1x read |
| busy | output | 1 | High while a slot is running |
| done | output | 1 | One-cycle pulse at the end of a slot |
| rd_bit | output | 1 | Bit returned by the last slot (0 for writes) |
| line_oe | output | 1 | High to pull the line low, low to release it |
| line_in | input | 1 | Level of the one-wire line |

## Verification
The hardest condition to reach is a target that lets go of the line within a few clock cycles of the data-valid deadline. The decision then depends on the synchronizer latency and the exact prescaler phase. The bench models a target that holds the line low for a programmed number of cycles from the master's falling edge. It sweeps that hold across the deadline, including a pair of values one cycle apart that must give opposite bits. A start pulse injected in the middle of a long write-zero slot covers the command that must be ignored.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DRIVE   = 2'd1,
    ST_RELEASE = 2'd2
  } slot_state_t;

  typedef struct packed {
    logic is_read;
    logic wval;
  } slot_cmd_t;

  function automatic slot_cmd_t decode_cmd(input logic [1:0] c);
    slot_cmd_t r;
    r.is_read = c[1];
    r.wval    = c[0];
    return r;
  endfunction

endpackage

// File: rtl/ow_us_timer.sv
module ow_us_timer #(
  parameter int CLK_PER_US = 50,
  parameter int US_W       = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            run,
  output logic            tick,
  output logic [US_W-1:0] us_cnt
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] presc;

  assign tick = run && (presc == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      presc  <= '0;
      us_cnt <= '0;
    end else if (run) begin
      if (presc == PRE_LAST) begin
        presc  <= '0;
        us_cnt <= us_cnt + US_W'(1);
      end else begin
        presc <= presc + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
  import ow_slot_pkg::*;
#(
  parameter int US_W   = 7,
  parameter int T_SLOT = 60,
  parameter int T_REC  = 1,
  parameter int T_LOW0 = 60,
  parameter int T_LOW1 = 6,
  parameter int T_LOWR = 6,
  parameter int T_RDV  = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      cmd,
  input  logic            tick,
  input  logic [US_W-1:0] us_cnt,
  input  logic            line_s,
  output logic            tmr_clear,
  output logic            tmr_run,
  output logic            busy,
  output logic            done,
  output logic            rd_bit,
  output logic            line_oe
);
  localparam logic [US_W-1:0] US_TOTAL = US_W'(T_SLOT + T_REC);
  localparam logic [US_W-1:0] US_LOW0  = US_W'(T_LOW0);
  localparam logic [US_W-1:0] US_LOW1  = US_W'(T_LOW1);
  localparam logic [US_W-1:0] US_LOWR  = US_W'(T_LOWR);
  localparam logic [US_W-1:0] US_RDV   = US_W'(T_RDV);

  slot_state_t     state;
  slot_cmd_t       cur;
  logic            seen_high;
  logic [US_W-1:0] us_nxt;
  logic [US_W-1:0] low_len;
  logic            low_end;
  logic            slot_end;
  logic            sample_en;

  assign us_nxt    = us_cnt + US_W'(1);
  assign low_len   = cur.is_read ? US_LOWR : (cur.wval ? US_LOW1 : US_LOW0);
  assign low_end   = (state == ST_DRIVE) && tick && (us_nxt == low_len);
  assign slot_end  = (state != ST_IDLE) && tick && (us_nxt == US_TOTAL);
  assign sample_en = (state == ST_RELEASE) && cur.is_read && (us_cnt < US_RDV);

  assign tmr_clear = (state == ST_IDLE);
  assign tmr_run   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur       <= '0;
      seen_high <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rd_bit    <= 1'b0;
      line_oe   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_DRIVE;
            cur       <= decode_cmd(cmd);
            seen_high <= 1'b0;
            busy      <= 1'b1;
            line_oe   <= 1'b1;
          end
        end
        ST_DRIVE: begin
          if (low_end) begin
            state   <= ST_RELEASE;
            line_oe <= 1'b0;
          end
        end
        ST_RELEASE: begin
          if (sample_en && line_s) seen_high <= 1'b1;
          if (slot_end) begin
            state  <= ST_IDLE;
            busy   <= 1'b0;
            done   <= 1'b1;
            rd_bit <= cur.is_read ? (seen_high | (sample_en & line_s)) : 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine #(
  parameter int CLK_PER_US  = 50,
  parameter int T_SLOT      = 60,
  parameter int T_REC       = 1,
  parameter int T_LOW0      = 60,
  parameter int T_LOW1      = 6,
  parameter int T_LOWR      = 6,
  parameter int T_RDV       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] cmd,
  output logic       busy,
  output logic       done,
  output logic       rd_bit,
  output logic       line_oe,
  input  logic       line_in
);
  localparam int US_W = $clog2(T_SLOT + T_REC + 1);

  logic            tick;
  logic [US_W-1:0] us_cnt;
  logic            tmr_clear;
  logic            tmr_run;
  logic            line_s;

  ow_us_timer #(
    .CLK_PER_US (CLK_PER_US),
    .US_W       (US_W)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (tmr_clear),
    .run    (tmr_run),
    .tick   (tick),
    .us_cnt (us_cnt)
  );

  ow_line_sync #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (line_s)
  );

  ow_slot_fsm #(
    .US_W   (US_W),
    .T_SLOT (T_SLOT),
    .T_REC  (T_REC),
    .T_LOW0 (T_LOW0),
    .T_LOW1 (T_LOW1),
    .T_LOWR (T_LOWR),
    .T_RDV  (T_RDV)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd       (cmd),
    .tick      (tick),
    .us_cnt    (us_cnt),
    .line_s    (line_s),
    .tmr_clear (tmr_clear),
    .tmr_run   (tmr_run),
    .busy      (busy),
    .done      (done),
    .rd_bit    (rd_bit),
    .line_oe   (line_oe)
  );
endmodule

// File: rtl/ow_slot_engine_chk.sv
module ow_slot_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] cmd,
  input logic       busy,
  input logic       done,
  input logic       rd_bit,
  input logic       line_oe
);
  // R1 R2 R3: the line is pulled low only inside a slot
  p_oe_in_slot_r3: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> busy);

  // R1: a slot always begins with the pull-down
  p_start_pulls_low_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> line_oe);

  // R4: done lasts a single cycle
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: done follows the fall of busy
  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R7: once running, a slot is not restarted by start
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !line_oe && start) |=> !$rose(line_oe));

  // R8: the returned bit only moves on the done cycle
  p_bit_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rd_bit));
endmodule

bind ow_slot_engine ow_slot_engine_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .cmd     (cmd),
  .busy    (busy),
  .done    (done),
  .rd_bit  (rd_bit),
  .line_oe (line_oe)
);

// File: tb/ow_slot_engine_tb_top.sv
module ow_slot_engine_tb_top;
  localparam int CPU    = 50;
  localparam int T_SLOT = 60;
  localparam int T_REC  = 1;
  localparam int T_LOW0 = 60;
  localparam int T_LOW1 = 6;
  localparam int T_LOWR = 6;
  localparam int T_RDV  = 15;
  localparam int TOTAL  = (T_SLOT + T_REC) * CPU;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic       busy, done, rd_bit, line_oe;
  logic       line_in;
  logic       tgt_low = 1'b0;
  int         tgt_cnt = 0;
  int         hold_cyc = 0;
  logic       prev_oe = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  assign line_in = !line_oe && !tgt_low;

  ow_slot_engine #(
    .CLK_PER_US (CPU), .T_SLOT (T_SLOT), .T_REC (T_REC),
    .T_LOW0 (T_LOW0), .T_LOW1 (T_LOW1), .T_LOWR (T_LOWR), .T_RDV (T_RDV)
  ) dut_i (
    .clk (clk), .rst (rst), .start (start), .cmd (cmd),
    .busy (busy), .done (done), .rd_bit (rd_bit),
    .line_oe (line_oe), .line_in (line_in)
  );

  // target: holds the line low for hold_cyc cycles after the master falls
  always @(posedge clk) begin
    prev_oe <= line_oe;
    if (line_oe && !prev_oe) tgt_cnt <= hold_cyc;
    else if (tgt_cnt > 0)    tgt_cnt <= tgt_cnt - 1;
  end
  always @(posedge clk) tgt_low <= (line_oe && !prev_oe) ? (hold_cyc > 0) : (tgt_cnt > 1);

  // behavioural reference model
  int   m_e = 0;
  int   m_tlow = 0;
  bit   m_busy = 0, m_done = 0, m_oe = 0, m_bit = 0, m_rd = 0, m_seen = 0;
  bit   syn[$];

  initial begin
    syn.push_back(1'b0);
    syn.push_back(1'b0);
  end

  always @(posedge clk) begin
    bit s_old;
    s_old = syn[0];
    if (rst) begin
      m_busy = 0; m_done = 0; m_oe = 0; m_bit = 0; m_seen = 0; m_e = 0;
      syn.delete(); syn.push_back(1'b0); syn.push_back(1'b0);
    end else begin
      void'(syn.pop_front());
      syn.push_back(line_in);
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_oe = 1; m_e = 0; m_seen = 0;
          m_rd = cmd[1];
          m_tlow = cmd[1] ? T_LOWR : (cmd[0] ? T_LOW1 : T_LOW0);
        end
      end else begin
        if (m_rd && !m_oe && (m_e / CPU) < T_RDV && s_old) m_seen = 1;
        m_e = m_e + 1;
        if (m_e == m_tlow * CPU) m_oe = 0;
        if (m_e == TOTAL) begin
          m_busy = 0; m_done = 1; m_bit = m_rd ? m_seen : 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R1 R2 R3 line_oe", line_oe, m_oe);
      chk("R4 busy", busy, m_busy);
      chk("R4 done", done, m_done);
      chk("R5 R8 rd_bit", rd_bit, m_bit);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_slot(input logic [1:0] c, input int hold, input int exp_low,
                          input int exp_bit, input int glitch_at, input string tag);
    int lo = 0;
    int bz = 0;
    hold_cyc = hold;
    @(posedge clk); #1;
    start = 1'b1; cmd = c;
    @(posedge clk); #1;
    start = 1'b0;
    forever begin
      @(negedge clk);
      if (line_oe) lo++;
      if (busy) bz++;
      if (done) break;
      if (glitch_at > 0 && bz == glitch_at) begin start = 1'b1; cmd = 2'b01; end
      else start = 1'b0;
    end
    start = 1'b0;
    chk({tag, " low width"}, lo, exp_low);
    chk("R4 slot length", bz, TOTAL);
    chk({tag, " returned bit"}, rd_bit, exp_bit);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R9 reset line_oe", line_oe, 0);
    chk("R9 reset rd_bit", rd_bit, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R9 idle after reset", busy | done | line_oe | rd_bit, 0);

    run_slot(2'b01, 0, T_LOW1 * CPU, 0, 0, "R1 write one");
    run_slot(2'b00, 0, T_LOW0 * CPU, 0, 0, "R2 write zero");
    // R5 R6: target releases immediately, before and across the deadline
    run_slot(2'b10, 0,          T_LOWR * CPU, 1, 0, "R3 R5 read fast");
    run_slot(2'b11, 10 * CPU,   T_LOWR * CPU, 1, 0, "R3 R5 read 10us");
    run_slot(2'b10, 746,        T_LOWR * CPU, 1, 0, "R5 R6 edge before deadline");
    run_slot(2'b10, 747,        T_LOWR * CPU, 0, 0, "R5 R6 edge at deadline");
    run_slot(2'b10, 30 * CPU,   T_LOWR * CPU, 0, 0, "R5 read zero");
    run_slot(2'b10, 0,          T_LOWR * CPU, 1, 0, "R8 read one again");
    // R8: a write clears the returned bit
    run_slot(2'b01, 0, T_LOW1 * CPU, 0, 0, "R8 write after read");
    // R7: start mid-slot during a long write zero
    run_slot(2'b00, 0, T_LOW0 * CPU, 0, 1000, "R7 start while busy");
    repeat (3) begin
      @(negedge clk);
      chk("R7 no queued slot", busy, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule